// File: doc/BRIEF.md
# 8-bit Multi-Cycle Instruction Sequencer

This block is a compact processor core. It fetches opcodes one byte at a time from a synchronous memory port and executes a subset of a classic 8-bit accumulator instruction set. The subset covers immediate byte loads, register-to-register copies, loads and stores through the BC, DE and HL pairs (HL may step up or down after the access), 16-bit immediate loads into BC and DE, BC increment and decrement, an absolute jump, XOR into the accumulator, a halt and a two-byte stop. The core holds the byte registers A, B, C, D, E, H and L and a 16-bit program counter. No instruction in this subset reads a flag, so the core keeps no flag register.

The memory port has a single 16-bit address, a write strobe with write data, and read data that returns one clock after the address is presented. Every instruction starts with a fetch cycle and a decode cycle. A state machine then adds one cycle for each further byte the instruction moves. After a halt or a stop, the core raises `halted` and waits there until reset.

Top module: `byte_seq_core`

## Requirements
- R1: Reset sets the program counter to RESET_PC (0x0000 by default). Right after reset is released, `mem_addr` shows that value, `halted` is low and `mem_we` is low.
- R2: Opcode pattern 00ddd110 loads the byte after the opcode into register d, using the codes B=0, C=1, D=2, E=3, H=4, L=5, A=7. With d=6 (0x36), that byte is instead written to address HL.
- R3: Opcode pattern 01dddsss copies source s to destination d with the same register codes. Code 6 means the memory byte at HL: as a source it is read, as a destination it is written. Opcode 0x76 is excluded from this pattern.
- R4: Opcode 0x76 stops execution and raises `halted`.
- R5: 0x02 and 0x12 write A to address BC and address DE. 0x0A and 0x1A load A from those addresses.
- R6: 0x22 (write) and 0x2A (read) move A through address HL and then add one to HL. 0x32 and 0x3A do the same and then subtract one. HL wraps modulo 65536.
- R7: 0x01 loads BC and 0x11 loads DE from the two bytes after the opcode. The lower address holds the low byte.
- R8: 0x03 adds one to BC and 0x0B subtracts one from BC, both modulo 65536.
- R9: 0xC3 loads the program counter with the two bytes after the opcode, low byte first.
- R10: 0x10 skips the byte after it without reading it and stops execution. Once `halted` is high it stays high until reset, and no write is issued while it is high.
- R11: Opcode pattern 10101sss replaces A with A XOR source s, where s=6 reads the byte at HL. 0xEE XORs the byte after the opcode into A.
- R12: Any opcode not listed above is one byte long, takes two cycles and changes neither registers nor memory.
- R13: An instruction takes two cycles, plus one cycle for each operand or data byte it reads or writes. The exception is 0x36, which takes three cycles because its write happens in the same cycle as its immediate byte arrives. 0x76 and 0x10 take two cycles. Two writes never occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current cycle |
| mem_rdata | input | 8 | Read data for the address presented one cycle earlier |
| mem_wdata | output | 8 | Write data, valid while mem_we is high |
| mem_we | output | 1 | Write strobe, one cycle per written byte |
| halted | output | 1 | High once a halt or stop has executed |

## Verification
Two functions can land in the same cycle. In the first, an HL post-step store drives the old HL on the address bus while the pair is being stepped; it is provoked with HL set to 0xFFFF and then stepped across the wrap in both directions. In the second, the 0x36 immediate arrives in the same cycle as the write it feeds; it is provoked by placing 0x36 at random data addresses. An instruction-level model in the bench predicts every write address and value in order, plus the total cycle count up to `halted`. Either collision would show up as a write at the stepped address, stale write data, or a cycle count that is off by one. Fixed-seed random programs mix all instruction kinds, and directed programs cover pointer wrap, jumps over halt bytes, and a stop followed by bytes that must never execute.

// File: rtl/byte_seq_core.sv
module byte_seq_core #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        halted
);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OP1, S_OP2, S_WR, S_HALT} state_t;

  state_t      st;
  logic [15:0] pc;
  logic [7:0]  ir, lo;
  logic [7:0]  rf [0:7];

  logic [7:0]  op, acc;
  logic [2:0]  dst, src;
  logic [15:0] bc, de, hl, ptr_x, hl_next;
  logic        is_ldi8, is_ldx, is_ld16, is_jp, is_mov, is_xor, is_xori, is_halt, is_stop;

  assign op   = (st == S_DEC) ? mem_rdata : ir;
  assign dst  = op[5:3];
  assign src  = op[2:0];
  assign acc  = rf[7];
  assign bc   = {rf[0], rf[1]};
  assign de   = {rf[2], rf[3]};
  assign hl   = {rf[4], rf[5]};

  assign is_ldi8 = (op[7:6] == 2'b00) && (op[2:0] == 3'b110);
  assign is_ldx  = (op[7:6] == 2'b00) && (op[2:0] == 3'b010);
  assign is_ld16 = (op == 8'h01) || (op == 8'h11);
  assign is_jp   = (op == 8'hC3);
  assign is_halt = (op == 8'h76);
  assign is_stop = (op == 8'h10);
  assign is_mov  = (op[7:6] == 2'b01) && !is_halt;
  assign is_xor  = (op[7:3] == 5'b10101);
  assign is_xori = (op == 8'hEE);

  assign ptr_x   = (op[5:4] == 2'b00) ? bc : (op[5:4] == 2'b01) ? de : hl;
  assign hl_next = op[4] ? hl - 16'd1 : hl + 16'd1;
  assign halted  = (st == S_HALT);

  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = acc;
    case (st)
      S_DEC: begin
        if (is_ldx && op[3])
          mem_addr = ptr_x;
        else if ((is_mov || is_xor) && src == 3'd6)
          mem_addr = hl;
      end
      S_OP1: begin
        if (is_ldi8 && dst == 3'd6) begin
          mem_addr  = hl;
          mem_we    = 1'b1;
          mem_wdata = mem_rdata;
        end
      end
      S_WR: begin
        mem_we = 1'b1;
        if (is_ldx) begin
          mem_addr = ptr_x;
        end else begin
          mem_addr  = hl;
          mem_wdata = rf[src];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH;
      pc <= RESET_PC;
      ir <= 8'h00;
      lo <= 8'h00;
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else begin
      case (st)
        S_FETCH: begin
          pc <= pc + 16'd1;
          st <= S_DEC;
        end
        S_DEC: begin
          ir <= op;
          st <= S_FETCH;
          if (is_halt) begin
            st <= S_HALT;
          end else if (is_stop) begin
            pc <= pc + 16'd1;
            st <= S_HALT;
          end else if (is_ldi8 || is_ld16 || is_jp || is_xori) begin
            pc <= pc + 16'd1;
            st <= S_OP1;
          end else if (is_ldx) begin
            if (op[3]) begin
              st <= S_OP1;
              if (op[5]) {rf[4], rf[5]} <= hl_next;
            end else begin
              st <= S_WR;
            end
          end else if (is_mov) begin
            if (src == 3'd6)      st <= S_OP1;
            else if (dst == 3'd6) st <= S_WR;
            else                  rf[dst] <= rf[src];
          end else if (is_xor) begin
            if (src == 3'd6) st <= S_OP1;
            else             rf[7] <= acc ^ rf[src];
          end else if (op == 8'h03) begin
            {rf[0], rf[1]} <= bc + 16'd1;
          end else if (op == 8'h0B) begin
            {rf[0], rf[1]} <= bc - 16'd1;
          end
        end
        S_OP1: begin
          st <= S_FETCH;
          if (is_ld16 || is_jp) begin
            lo <= mem_rdata;
            pc <= pc + 16'd1;
            st <= S_OP2;
          end else if (is_ldi8) begin
            if (dst != 3'd6) rf[dst] <= mem_rdata;
          end else if (is_ldx) begin
            rf[7] <= mem_rdata;
          end else if (is_mov) begin
            rf[dst] <= mem_rdata;
          end else begin
            rf[7] <= acc ^ mem_rdata;
          end
        end
        S_OP2: begin
          st <= S_FETCH;
          if (is_jp)      pc <= {mem_rdata, lo};
          else if (op[4]) {rf[2], rf[3]} <= {mem_rdata, lo};
          else            {rf[0], rf[1]} <= {mem_rdata, lo};
        end
        S_WR: begin
          st <= S_FETCH;
          if (is_ldx && op[5]) {rf[4], rf[5]} <= hl_next;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/byte_seq_core_chk.sv
module byte_seq_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reset_pc,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_rdata,
  input logic        mem_we,
  input logic        halted,
  input logic        in_dec,
  input logic        in_wr,
  input logic [7:0]  ir,
  input logic [15:0] bc,
  input logic [15:0] hl
);

  // R1
  reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mem_addr == reset_pc && !halted && !mem_we));

  // R4
  halt_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dec && mem_rdata == 8'h76) |=> halted);

  // R10
  stop_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dec && mem_rdata == 8'h10) |=> halted);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R13
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6
  hl_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && ir == 8'h22) |=> (hl == 16'($past(hl) + 16'd1)));

  // R6
  hl_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && ir == 8'h32) |=> (hl == 16'($past(hl) - 16'd1)));

  // R8
  bc_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dec && mem_rdata == 8'h0B) |=> (bc == 16'($past(bc) - 16'd1)));

endmodule

bind byte_seq_core byte_seq_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_pc(RESET_PC), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted),
  .in_dec(st == S_DEC), .in_wr(st == S_WR), .ir(ir), .bc(bc), .hl(hl)
);

// File: tb/sim_byte_seq_core.sv
`timescale 1ns/1ps
module sim_byte_seq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;

  always #4 clk = ~clk;

  byte_seq_core u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
                    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted));

  logic [7:0]  tm [0:4095];
  logic [7:0]  im [0:4095];
  logic [7:0]  q  [0:7];
  logic [15:0] ew_a [0:1023];
  logic [7:0]  ew_d [0:1023];
  int ew_n, wi, wp;
  int n_chk = 0, n_fail = 0;
  string cur_req;

  always @(posedge clk) begin
    if (mem_we) tm[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= tm[mem_addr[11:0]];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wi < ew_n) begin
        chk(mem_addr == ew_a[wi] && mem_wdata == ew_d[wi], cur_req, "write addr/data",
            {mem_addr, mem_wdata}, {ew_a[wi], ew_d[wi]});
      end else begin
        chk(1'b0, "R10", "unexpected write", {mem_addr, mem_wdata}, 0);
      end
      wi++;
    end
  end

  function automatic logic [7:0] rd(input logic [15:0] a);
    return im[a[11:0]];
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    im[a[11:0]] = d;
    ew_a[ew_n] = a;
    ew_d[ew_n] = d;
    ew_n++;
  endtask

  task automatic iss_run(output int cyc);
    logic [15:0] pc, ptr, hl;
    logic [7:0]  o, v;
    bit done;
    cyc = 0; pc = 16'h0000; done = 0; ew_n = 0;
    for (int i = 0; i < 8; i++) q[i] = 8'h00;
    for (int steps = 0; steps < 3000 && !done; steps++) begin
      o = rd(pc); pc = pc + 16'd1; cyc += 2;
      hl = {q[4], q[5]};
      if (o == 8'h76) done = 1;
      else if (o == 8'h10) begin pc = pc + 16'd1; done = 1; end
      else if (o[7:6] == 2'b00 && o[2:0] == 3'b110) begin
        v = rd(pc); pc = pc + 16'd1; cyc += 1;
        if (o[5:3] == 3'd6) wr(hl, v); else q[o[5:3]] = v;
      end else if (o[7:6] == 2'b00 && o[2:0] == 3'b010) begin
        ptr = (o[5:4] == 2'd0) ? {q[0], q[1]} : (o[5:4] == 2'd1) ? {q[2], q[3]} : hl;
        if (o[3]) q[7] = rd(ptr); else wr(ptr, q[7]);
        cyc += 1;
        if (o[5]) {q[4], q[5]} = o[4] ? hl - 16'd1 : hl + 16'd1;
      end else if (o == 8'h01 || o == 8'h11) begin
        if (o[4]) begin q[3] = rd(pc); q[2] = rd(pc + 16'd1); end
        else      begin q[1] = rd(pc); q[0] = rd(pc + 16'd1); end
        pc = pc + 16'd2; cyc += 2;
      end else if (o == 8'h03) {q[0], q[1]} = {q[0], q[1]} + 16'd1;
      else if (o == 8'h0B) {q[0], q[1]} = {q[0], q[1]} - 16'd1;
      else if (o == 8'hC3) begin pc = {rd(pc + 16'd1), rd(pc)}; cyc += 2; end
      else if (o[7:6] == 2'b01) begin
        if (o[2:0] == 3'd6) begin v = rd(hl); cyc += 1; end else v = q[o[2:0]];
        if (o[5:3] == 3'd6) begin wr(hl, v); cyc += 1; end else q[o[5:3]] = v;
      end else if (o[7:3] == 5'b10101) begin
        if (o[2:0] == 3'd6) begin v = rd(hl); cyc += 1; end else v = q[o[2:0]];
        q[7] = q[7] ^ v;
      end else if (o == 8'hEE) begin
        q[7] = q[7] ^ rd(pc); pc = pc + 16'd1; cyc += 1;
      end
    end
  endtask

  task automatic emit(input logic [7:0] b);
    tm[wp[11:0]] = b;
    wp++;
  endtask

  function automatic logic [15:0] data_addr();
    return 16'h0800 + 16'($urandom_range(0, 16'h07EF));
  endfunction

  task automatic set_hl();
    logic [15:0] a;
    a = data_addr();
    emit(8'h26); emit(a[15:8]); emit(8'h2E); emit(a[7:0]);
  endtask

  function automatic logic [2:0] pick_reg();
    logic [2:0] r;
    r = 3'($urandom_range(0, 6));
    return (r == 3'd6) ? 3'd7 : r;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) tm[i] = (i < 2048) ? 8'h76 : 8'($urandom);
    wp = 0;
  endtask

  task automatic gen_random();
    logic [7:0]  nop_ops [0:7];
    logic [15:0] a;
    int sk;
    nop_ops = '{8'h00, 8'h04, 8'h27, 8'h80, 8'h9F, 8'hC9, 8'hFF, 8'hCB};
    clear_mem();
    for (int k = 0; k < 40; k++) begin
      case ($urandom_range(0, 10))
        0: begin emit({2'b00, pick_reg(), 3'b110}); emit(8'($urandom)); end
        1: begin set_hl(); emit(8'h36); emit(8'($urandom)); end
        2: emit({2'b01, pick_reg(), pick_reg()});
        3: begin set_hl(); emit({2'b01, pick_reg(), 3'd6}); end
        4: begin set_hl(); emit({2'b01, 3'd6, pick_reg()}); end
        5: begin
          sk = $urandom_range(0, 2);
          a = data_addr();
          if (sk == 2) set_hl();
          else begin emit(sk == 0 ? 8'h01 : 8'h11); emit(a[7:0]); emit(a[15:8]); end
          emit({2'b00, 2'(sk == 2 ? 2 + $urandom_range(0, 1) : sk), 1'($urandom_range(0, 1)), 3'b010});
        end
        6: begin emit($urandom_range(0, 1) ? 8'h01 : 8'h11); emit(8'($urandom)); emit(8'($urandom)); end
        7: emit($urandom_range(0, 1) ? 8'h03 : 8'h0B);
        8: begin
          sk = $urandom_range(0, 2);
          if (sk == 0) emit({5'b10101, pick_reg()});
          else if (sk == 1) begin emit(8'hEE); emit(8'($urandom)); end
          else begin set_hl(); emit(8'hAE); end
        end
        9: begin
          sk = $urandom_range(0, 2);
          a = 16'(wp + 3 + sk);
          emit(8'hC3); emit(a[7:0]); emit(a[15:8]);
          for (int j = 0; j < sk; j++) emit(8'h76);
        end
        default: emit(nop_ops[$urandom_range(0, 7)]);
      endcase
    end
    if ($urandom_range(0, 1)) emit(8'h76);
    else begin emit(8'h10); emit(8'h36); end
  endtask

  task automatic run_test(input string req);
    int exp_cyc, n;
    int mism, first;
    cur_req = req;
    for (int i = 0; i < 4096; i++) im[i] = tm[i];
    iss_run(exp_cyc);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!halted && !mem_we, "R1", "idle in reset", {halted, mem_we}, 0);
    wi = 0;
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 16'h0000 && !halted, "R1", "first fetch address", mem_addr, 0);
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (halted) break;
      if (n > 20000) break;
    end
    chk(halted, "R4", "reached halt", halted, 1);
    chk(n == exp_cyc, "R13", "cycles to halt", n, exp_cyc);
    repeat (6) @(negedge clk);
    chk(halted, "R10", "halt held", halted, 1);
    chk(wi == ew_n, req, "write count", wi, ew_n);
    mism = 0; first = 0;
    for (int i = 0; i < 4096; i++)
      if (tm[i] !== im[i]) begin if (mism == 0) first = i; mism++; end
    chk(mism == 0, req, "memory image", {first, tm[first]}, {first, im[first]});
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R13", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] t;
    void'($urandom(32'd20240611));
    ew_n = 0; wi = 0;

    // R4 R12: unused opcodes then halt
    clear_mem();
    emit(8'h00); emit(8'hCB); emit(8'hFF); emit(8'h76);
    run_test("R12");

    // R6 R8 R5: pointer wrap in both directions
    clear_mem();
    emit(8'h26); emit(8'hFF); emit(8'h2E); emit(8'hFF);
    emit(8'h3E); emit(8'h5A); emit(8'h22);
    emit(8'h3E); emit(8'hA5); emit(8'h32);
    emit(8'h2A); emit(8'h3A); emit(8'h77);
    emit(8'h01); emit(8'hFF); emit(8'hFF); emit(8'h03); emit(8'h02);
    emit(8'h0B); emit(8'h0B); emit(8'h02);
    emit(8'h11); emit(8'h34); emit(8'h09); emit(8'h1A); emit(8'h12);
    emit(8'h76);
    run_test("R6 R8 R5 R7");

    // R10: stop skips a byte and nothing after it runs
    clear_mem();
    emit(8'h3E); emit(8'h11); emit(8'h01); emit(8'h00); emit(8'h09);
    emit(8'h02); emit(8'h10); emit(8'h02); emit(8'h02); emit(8'h02);
    run_test("R10");

    // R9: jump over halt bytes, then R2 R3 R11
    clear_mem();
    t = 16'h0010;
    emit(8'hC3); emit(t[7:0]); emit(t[15:8]); emit(8'h76); emit(8'h76);
    wp = 16;
    emit(8'h26); emit(8'h0A); emit(8'h2E); emit(8'h20);
    emit(8'h36); emit(8'hC4); emit(8'h7E); emit(8'hEE); emit(8'h0F);
    emit(8'h47); emit(8'hA8); emit(8'hAE); emit(8'h23 - 8'h23 + 8'h2C);
    emit(8'h70); emit(8'h77); emit(8'h76);
    run_test("R9 R2 R3 R11");

    // R3: every register copy once, then store all registers
    clear_mem();
    for (int r = 0; r < 8; r++)
      if (r != 6) begin emit({2'b00, 3'(r), 3'b110}); emit(8'(8'h11 * (r + 1))); end
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++)
        if (d != 6 && s != 6) emit({2'b01, 3'(d), 3'(s)});
    emit(8'h26); emit(8'h0C); emit(8'h2E); emit(8'h00);
    for (int s = 0; s < 8; s++) if (s != 6) begin emit({2'b01, 3'd6, 3'(s)}); emit(8'h2C); end
    emit(8'h76);
    run_test("R3");

    for (int k = 0; k < 30; k++) begin
      gen_random();
      run_test("R2/R3/R5/R6/R7/R8/R9/R11/R12");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule